// File: doc/BRIEF.md
# Programmable Down-Counter Timer Core

This block is one timer channel driven through a small synchronous register port. A 3-bit word index selects a register. Writes are taken on the clock edge where `bus_wr` is high. Read data is combinational from the index, and a read has no side effects. Once enabled, the counter drops by one on every prescaler tick. The tick comes at the clock rate divided by 1, 16 or 256. When the count expires, a raw interrupt flag is set. That flag, gated by an enable bit, drives the interrupt pin.

There are two ways to set the reload value. An immediate load replaces both the reload value and the running count. A background load changes only the value used at the next reload, so software can retime the following period without disturbing the current one. Three counting behaviours are available. Periodic mode reloads from the stored value. Free-running mode wraps to the all-ones count of the selected width. One-shot mode stops at zero. The counter can be 16 or 32 bits wide.

Top module: `dctimer_core`

## Requirements
- R1: After reset, Control (index 2) reads 0x20, Value (index 1) reads 0, raw status (index 4) reads 0, and `irq_out` is low.
- R2: Index 0 (Load) and index 6 (background load) both read back the last value written to either of them. Control reads back bits 7:0 as written, with zeros above. An unmapped index (7) reads 0.
- R3: A write to index 0 sets the count on that same edge, even if a tick occurs in that cycle. When Control bit 1 is 0 (16-bit size), only bits 15:0 of the load value are used, and Value bits 31:16 read 0. When bit 1 is 1, all 32 bits are used.
- R4: A write to index 6 leaves the current count as it is. The new value takes effect at the next reload.
- R5: Writes to index 1 (Value) and to index 7 change no register.
- R6: In periodic mode (Control bit 6 set, bit 0 clear), each tick lowers the count by one. The tick that finds a count of 1 (or 0) sets the raw flag and reloads the load value. A load of N therefore gives one event every N ticks.
- R7: In free-running mode (bits 6 and 0 both clear), the expiring tick sets the raw flag and reloads 0xFFFF in 16-bit size or 0xFFFFFFFF in 32-bit size, whatever the load value.
- R8: One-shot mode (bit 0 set) takes priority over bit 6. The expiring tick sets the raw flag and leaves the count at 0. The count then holds at 0 and raises no further events until index 0 is written.
- R9: Ticks occur only while bit 7 is set. Bits 3:2 choose the divisor: 00 gives 1, 01 gives 16, 10 gives 256, and 11 gives 1.
- R10: Any Control write restarts the prescaler. With divisor D and bit 7 set, the first tick lands on the D-th clock edge after the write edge.
- R11: `irq_out` is high exactly when the raw flag is set and bit 5 is set. Raw status bit 0 reads the flag. Masked status (index 5) bit 0 reads flag AND bit 5.
- R12: Any write to index 3 clears the raw flag. An expiry in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_idx | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_idx`, combinational |
| irq_out | output | 1 | Masked interrupt |

## Verification
Periodic mode is swept over load values 1 through 8. Each step checks that the count is 1 on the edge before expiry and that expiry reloads the load value, which separates a period of N from a period of N+1. The same expiry is then driven in the three modes and both sizes. This tells apart reload-from-load, wrap-to-width-maximum and hold-at-zero, and shows whether the upper half is masked in 16-bit size. Prescaler tests sample exactly one edge before and at the D-th edge for all four divisor codes, and once after a mid-interval Control rewrite, which shows whether the prescaler restarted. Background and immediate loads are issued while counting, so a design that mixes up the two paths shows a count that differs by one or by the whole new value.

// File: rtl/dct_pkg.sv
package dct_pkg;

  localparam int CTRL_W = 8;
  localparam int IDX_W  = 3;

  // register word indices
  localparam logic [IDX_W-1:0] IX_LOAD   = 3'd0;
  localparam logic [IDX_W-1:0] IX_VALUE  = 3'd1;
  localparam logic [IDX_W-1:0] IX_CTRL   = 3'd2;
  localparam logic [IDX_W-1:0] IX_CLEAR  = 3'd3;
  localparam logic [IDX_W-1:0] IX_RAW    = 3'd4;
  localparam logic [IDX_W-1:0] IX_MASKED = 3'd5;
  localparam logic [IDX_W-1:0] IX_BGLOAD = 3'd6;

  typedef enum logic [1:0] {
    CNT_FREE     = 2'd0,
    CNT_PERIODIC = 2'd1,
    CNT_ONESHOT  = 2'd2
  } cnt_mode_e;

  // control layout, bit 7 down to bit 0
  typedef struct packed {
    logic       run;
    logic       periodic;
    logic       irq_en;
    logic       spare;
    logic [1:0] psel;
    logic       wide;
    logic       oneshot;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{run: 1'b0, periodic: 1'b0, irq_en: 1'b1,
                                   spare: 1'b0, psel: 2'b00, wide: 1'b0,
                                   oneshot: 1'b0};

  // one-shot outranks periodic; neither selects free-running
  function automatic cnt_mode_e mode_of(input ctrl_t c);
    if (c.oneshot)       return CNT_ONESHOT;
    else if (c.periodic) return CNT_PERIODIC;
    else                 return CNT_FREE;
  endfunction

endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler #(
  parameter int LOG_MID = 4,
  parameter int LOG_HI  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] psel,
  output logic       tick
);
  localparam int PW = LOG_HI;
  localparam logic [PW-1:0] MID_LIM = PW'((1 << LOG_MID) - 1);
  localparam logic [PW-1:0] HI_LIM  = {PW{1'b1}};

  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] limit;

  function automatic logic [PW-1:0] limit_of(input logic [1:0] sel);
    case (sel)
      2'b01:   return MID_LIM;
      2'b10:   return HI_LIM;
      default: return '0;
    endcase
  endfunction

  assign limit = limit_of(psel);
  assign tick  = run && (pcnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (restart) pcnt_q <= '0;
    else if (tick)    pcnt_q <= '0;
    else if (run)     pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/dct_counter.sv
module dct_counter
  import dct_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  cnt_mode_e         mode,
  input  logic              wide,
  input  logic              load_wr,
  input  logic [DATA_W-1:0] load_data,
  input  logic [DATA_W-1:0] reload_val,
  output logic [DATA_W-1:0] cur,
  output logic              zero_evt
);
  localparam logic [DATA_W-1:0] NARROW_MASK =
    {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [DATA_W-1:0] count_q;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] reload;
  logic              is_last;

  function automatic logic [DATA_W-1:0] size_mask(input logic w);
    return w ? {DATA_W{1'b1}} : NARROW_MASK;
  endfunction

  function automatic logic [DATA_W-1:0] reload_of(input cnt_mode_e m,
      input logic [DATA_W-1:0] msk, input logic [DATA_W-1:0] rv);
    case (m)
      CNT_FREE: return msk;
      CNT_ONESHOT: return '0;
      default: return rv & msk;
    endcase
  endfunction

  assign mask    = size_mask(wide);
  assign cur     = count_q & mask;
  assign is_last = (cur <= DATA_W'(1));
  assign reload  = reload_of(mode, mask, reload_val);
  // a stopped one-shot sitting at zero raises nothing more
  assign zero_evt = tick && is_last && !(mode == CNT_ONESHOT && cur == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        count_q <= '0;
    else if (load_wr)  count_q <= load_data;
    else if (tick) begin
      if (is_last)     count_q <= reload;
      else             count_q <= cur - 1'b1;
    end
  end
endmodule

// File: rtl/dct_irq_flag.sv
module dct_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  input  logic irq_en,
  output logic raw,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)       raw <= 1'b0;
    else if (set_evt) raw <= 1'b1;
    else if (clr)     raw <= 1'b0;
  end

  assign irq = raw & irq_en;
endmodule

// File: rtl/dctimer_core.sv
module dctimer_core
  import dct_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int LOG_MID  = 4,
  parameter int LOG_HI   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [IDX_W-1:0]  bus_idx,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] load_q;
  logic              load_wr, bg_wr, ctrl_wr, clr_wr, val_wr;
  logic              tick, zero_evt, raw_flag;
  logic [DATA_W-1:0] cur;
  cnt_mode_e         mode;

  assign load_wr = bus_wr && (bus_idx == IX_LOAD);
  assign bg_wr   = bus_wr && (bus_idx == IX_BGLOAD);
  assign ctrl_wr = bus_wr && (bus_idx == IX_CTRL);
  assign clr_wr  = bus_wr && (bus_idx == IX_CLEAR);
  assign val_wr  = bus_wr && (bus_idx == IX_VALUE);
  assign mode    = mode_of(ctrl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
      load_q <= '0;
    end else begin
      if (ctrl_wr)          ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (load_wr || bg_wr) load_q <= bus_wdata;
    end
  end

  dct_prescaler #(.LOG_MID(LOG_MID), .LOG_HI(LOG_HI)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.run),
    .restart (ctrl_wr),
    .psel    (ctrl_q.psel),
    .tick    (tick)
  );

  dct_counter #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .mode       (mode),
    .wide       (ctrl_q.wide),
    .load_wr    (load_wr),
    .load_data  (bus_wdata),
    .reload_val (load_q),
    .cur        (cur),
    .zero_evt   (zero_evt)
  );

  dct_irq_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (zero_evt),
    .clr     (clr_wr),
    .irq_en  (ctrl_q.irq_en),
    .raw     (raw_flag),
    .irq     (irq_out)
  );

  always_comb begin
    case (bus_idx)
      IX_LOAD, IX_BGLOAD: bus_rdata = load_q;
      IX_VALUE:           bus_rdata = cur;
      IX_CTRL:            bus_rdata = DATA_W'(ctrl_q);
      IX_RAW:             bus_rdata = DATA_W'(raw_flag);
      IX_MASKED:          bus_rdata = DATA_W'(raw_flag & ctrl_q.irq_en);
      default:            bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dctimer_checker.sv
module dctimer_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_out,
  input logic              irq_en,
  input logic              run,
  input logic              oneshot,
  input logic              raw_flag,
  input logic              zero_evt,
  input logic              tick,
  input logic              clr_wr,
  input logic              val_wr,
  input logic              load_wr,
  input logic              ctrl_wr,
  input logic [DATA_W-1:0] cur
);
  a_r11_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> irq_en);

  a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> raw_flag);

  a_r6_flag_from_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_flag) |-> $past(zero_evt));

  a_r12_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !zero_evt) |=> !raw_flag);

  a_r5_value_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (val_wr && !tick) |=> $stable(cur));

  a_r9_no_tick_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);

  a_r8_oneshot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (oneshot && cur == '0 && !load_wr && !ctrl_wr) |=> (cur == '0));

  a_r6_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_wr && !ctrl_wr && cur > DATA_W'(1)) |=> (cur == $past(cur) - 1'b1));
endmodule

bind dctimer_core dctimer_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_out  (irq_out),
  .irq_en   (ctrl_q.irq_en),
  .run      (ctrl_q.run),
  .oneshot  (ctrl_q.oneshot),
  .raw_flag (raw_flag),
  .zero_evt (zero_evt),
  .tick     (tick),
  .clr_wr   (clr_wr),
  .val_wr   (val_wr),
  .load_wr  (load_wr),
  .ctrl_wr  (ctrl_wr),
  .cur      (cur)
);

// File: tb/dctimer_core_bench.sv
module dctimer_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_idx = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  int nvec = 0;
  int nbad = 0;

  always #2.5 clk = ~clk;

  dctimer_core u_dctimer_core (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_idx(bus_idx),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // control byte fields
  localparam logic [7:0] C_RUN = 8'h80, C_PER = 8'h40, C_IE = 8'h20,
                         C_WIDE = 8'h02, C_ONE = 8'h01;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    bus_idx = idx; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    bus_idx = idx;
    #1;
    d = bus_rdata;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  logic [31:0] v;

  initial begin
    #2_000_000;
    nbad++;
    $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    edges(4);
    rst_n = 1'b1;
    edges(1);

    // R1 reset state
    rd(3'd2, v); chk("R1 ctrl", v, 32'h20);
    rd(3'd1, v); chk("R1 value", v, 0);
    rd(3'd4, v); chk("R1 raw", v, 0);
    chk("R1 irq", {31'd0, irq_out}, 0);

    // R2 / R5 readback and ignored writes
    wr(3'd0, 32'h0001_2345);
    wr(3'd1, 32'hDEAD_BEEF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R2 load read", v, 32'h0001_2345);
    rd(3'd6, v); chk("R2 bg read", v, 32'h0001_2345);
    rd(3'd7, v); chk("R2 unmapped read", v, 0);
    rd(3'd2, v); chk("R5 ctrl untouched", v, 32'h20);
    // R3 narrow size masks upper half
    rd(3'd1, v); chk("R3 narrow value", v, 32'h0000_2345);
    wr(3'd2, 32'h5A);
    rd(3'd2, v); chk("R2 ctrl read", v, 32'h5A);
    wr(3'd2, {24'd0, C_PER | C_IE | C_WIDE});
    rd(3'd1, v); chk("R3 wide value", v, 32'h0001_2345);

    // R6 periodic sweep, divisor 1
    for (int n = 1; n <= 8; n++) begin
      wr(3'd2, {24'd0, C_PER | C_IE | C_WIDE});
      wr(3'd0, n);
      wr(3'd2, {24'd0, C_RUN | C_PER | C_IE | C_WIDE});
      edges(n - 1);
      rd(3'd1, v); chk("R6 before expiry", v, 1);
      rd(3'd4, v); chk("R6 no flag yet", v, 0);
      edges(1);
      rd(3'd1, v); chk("R6 reload", v, n);
      rd(3'd4, v); chk("R6 flag", v, 1);
      chk("R11 irq", {31'd0, irq_out}, 1);
      wr(3'd2, {24'd0, C_PER | C_IE | C_WIDE});
      wr(3'd3, 32'd0);
      rd(3'd4, v); chk("R12 cleared", v, 0);
    end

    // R3 narrow periodic uses low half of load
    wr(3'd2, {24'd0, C_PER | C_IE});
    wr(3'd0, 32'h0001_0003);
    wr(3'd2, {24'd0, C_RUN | C_PER | C_IE});
    edges(3);
    rd(3'd1, v); chk("R3 narrow period", v, 3);
    rd(3'd4, v); chk("R3 narrow flag", v, 1);

    // R4 background load while running, R3 immediate load while running
    wr(3'd2, {24'd0, C_PER | C_IE | C_WIDE});
    wr(3'd3, 0);
    wr(3'd0, 4);
    wr(3'd2, {24'd0, C_RUN | C_PER | C_IE | C_WIDE});
    wr(3'd6, 9);
    rd(3'd1, v); chk("R4 count kept", v, 3);
    rd(3'd0, v); chk("R4 stored", v, 9);
    edges(3);
    rd(3'd1, v); chk("R4 new reload", v, 9);
    wr(3'd0, 7);
    rd(3'd1, v); chk("R3 immediate load", v, 7);

    // R7 free-running, both sizes
    wr(3'd2, {24'd0, C_IE});
    wr(3'd3, 0);
    wr(3'd0, 3);
    wr(3'd2, {24'd0, C_RUN | C_IE});
    edges(3);
    rd(3'd1, v); chk("R7 wrap16", v, 32'hFFFF);
    rd(3'd4, v); chk("R7 flag16", v, 1);
    edges(1);
    rd(3'd1, v); chk("R7 next16", v, 32'hFFFE);
    wr(3'd2, {24'd0, C_IE | C_WIDE});
    wr(3'd0, 2);
    wr(3'd2, {24'd0, C_RUN | C_IE | C_WIDE});
    edges(2);
    rd(3'd1, v); chk("R7 wrap32", v, 32'hFFFF_FFFF);

    // R8 one-shot with periodic bit also set
    wr(3'd2, {24'd0, C_PER | C_IE | C_WIDE | C_ONE});
    wr(3'd3, 0);
    wr(3'd0, 3);
    wr(3'd2, {24'd0, C_RUN | C_PER | C_IE | C_WIDE | C_ONE});
    edges(3);
    rd(3'd1, v); chk("R8 at zero", v, 0);
    rd(3'd4, v); chk("R8 flag", v, 1);
    edges(5);
    rd(3'd1, v); chk("R8 holds", v, 0);
    wr(3'd3, 0);
    edges(4);
    rd(3'd4, v); chk("R8 no refire", v, 0);
    wr(3'd0, 2);
    rd(3'd1, v); chk("R8 reloaded", v, 2);
    edges(2);
    rd(3'd1, v); chk("R8 zero again", v, 0);
    rd(3'd4, v); chk("R8 flag again", v, 1);

    // R11 masking by interrupt enable
    wr(3'd2, {24'd0, C_RUN | C_WIDE | C_ONE});
    rd(3'd5, v); chk("R11 masked off", v, 0);
    rd(3'd4, v); chk("R11 raw kept", v, 1);
    chk("R11 irq off", {31'd0, irq_out}, 0);
    wr(3'd2, {24'd0, C_RUN | C_IE | C_WIDE | C_ONE});
    rd(3'd5, v); chk("R11 masked on", v, 1);
    chk("R11 irq on", {31'd0, irq_out}, 1);

    // R9 prescale codes: D-1 edges no tick, D-th edge ticks
    for (int code = 0; code < 4; code++) begin
      automatic int d = (code == 1) ? 16 : (code == 2) ? 256 : 1;
      wr(3'd2, {24'd0, C_PER | C_WIDE});
      wr(3'd0, 5);
      rd(3'd1, v); chk("R9 stopped", v, 5);
      wr(3'd2, {24'd0, C_RUN | C_PER | C_WIDE} | 8'(code << 2));
      edges(d - 1);
      rd(3'd1, v); chk("R9 before tick", v, 5);
      edges(1);
      rd(3'd1, v); chk("R9 at tick", v, 4);
    end

    // R10 prescaler restarts on control write
    wr(3'd2, {24'd0, C_PER | C_WIDE});
    wr(3'd0, 6);
    wr(3'd2, {24'd0, C_RUN | C_PER | C_WIDE | 8'h04});
    edges(9);
    wr(3'd2, {24'd0, C_RUN | C_PER | C_WIDE | 8'h04});
    edges(6);
    rd(3'd1, v); chk("R10 no early tick", v, 6);
    edges(9);
    rd(3'd1, v); chk("R10 before tick", v, 6);
    edges(1);
    rd(3'd1, v); chk("R10 tick", v, 5);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule